// File: doc/BRIEF.md
# Parameterised single-port block RAM

This block is a synchronous on-chip memory in which a single address serves both the read and the write of any given cycle. Its word width and word count are parameters. Only a fixed set of shapes is accepted: shapes whose width is a multiple of nine hold 9216 bits, and the others hold 8192 bits. A wrong pair stops elaboration. Writes can be limited to selected byte lanes. An address-hold input keeps the memory on the address it latched most recently. A parameter decides whether a read that coincides with a write returns the incoming word or the word that was stored before.

The read word leaves the array through a register on the input clock. It can then pass through an optional second register that has its own clock and clock enable, which adds one cycle of latency. An asynchronous clear zeroes the output and the latched address but leaves the stored words alone. With the packed option, one instance holds two independent memories of half depth each. Every per-port bus then carries two slices, and port 1 takes the upper slice.

Top module: `spram_block`

## Requirements
- R1: Legal (width x depth) shapes are 1x8192, 2x4096, 4x2048, 8x1024, 9x1024, 16x512, 18x512, 32x256 and 36x256. Any other pair halts elaboration. Every address from 0 to depth-1 (or depth/2-1 when packed) holds its own word.
- R2: On a rising `clk_in` edge with `ce_in` high, `wr_en` stores `wdata` at the address and `rd_en` loads the word at that same address into the read register.
- R3: With `RDW_NEW`=1, a cycle that has both `wr_en` and `rd_en` high returns the word as it stands after the write.
- R4: With `RDW_NEW`=0, a cycle that has both `wr_en` and `rd_en` high returns the word held at that address before the write.
- R5: While `rd_en` is low, the read register keeps the value from the last cycle in which `rd_en` was high, even if a write takes place.
- R6: For widths of 8 or more, `byte_en` bit i enables bits [i*L +: L]. L is 9 for widths that are multiples of nine and 8 otherwise. Lanes whose enable is low keep their stored bits.
- R7: For widths below 8, `byte_en` is ignored and every write stores the whole word.
- R8: While `addr_stall` is high, the memory uses the address latched in the previous enabled cycle for both read and write, and ignores `addr`.
- R9: While `ce_in` is low, nothing is written, the read register holds and the latched address holds.
- R10: With `OUT_REG`=1, `q` follows the read register one `clk_out` edge later, and it holds while `ce_out` is low. With `OUT_REG`=0, `q` is the read register itself.
- R11: `clr` asynchronously zeroes `q`, the read register and the latched address. Stored words are not changed.
- R12: With `PACKED`=1, two independent memories of depth/2 words each are built. Port p uses slice p of `wr_en`, `rd_en`, `addr_stall`, `addr`, `wdata`, `byte_en` and `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock for the array, the address latch and the read register |
| ce_in | input | 1 | Clock enable for everything on `clk_in` |
| clk_out | input | 1 | Clock for the optional output register |
| ce_out | input | 1 | Clock enable for the output register |
| clr | input | 1 | Asynchronous clear, active high |
| wr_en | input | NP | Write enable per port |
| rd_en | input | NP | Read enable per port |
| addr_stall | input | NP | Hold the latched address, per port |
| addr | input | NP*AW | Word address per port |
| wdata | input | NP*DATA_W | Write word per port |
| byte_en | input | NP*NL | Lane write enables per port |
| q | output | NP*DATA_W | Read word per port |

## Verification
The bench targets the read that coincides with a write under both settings, because a design with the setting inverted returns the wrong one of the two words. It also writes with `rd_en` low: a design that lets that write reach the read register shows a changed output. Partial-lane writes on a 9-bit-lane shape show whether lanes are cut at 8 bits instead of 9, and a narrow shape shows whether a clear byte enable wrongly blocks its writes. Address hold, clock-enable gating, the extra output stage (latency and hold), clear without loss of stored words, and the separation of the two packed halves are each driven so that a design mixing them up reads back a word that differs from the expected one.

// File: rtl/spram_pkg.sv
package spram_pkg;

  function automatic bit shape_ok(int w, int d);
    return (w == 1  && d == 8192) || (w == 2  && d == 4096) ||
           (w == 4  && d == 2048) || (w == 8  && d == 1024) ||
           (w == 9  && d == 1024) || (w == 16 && d == 512)  ||
           (w == 18 && d == 512)  || (w == 32 && d == 256)  ||
           (w == 36 && d == 256);
  endfunction

  // Width of one write lane; narrow words form a single lane of their own width.
  function automatic int lane_width(int w);
    if (w < 8)
      return w;
    return (w % 9 == 0) ? 9 : 8;
  endfunction

  function automatic int lane_count(int w);
    return w / lane_width(w);
  endfunction

endpackage

// File: rtl/spram_core.sv
module spram_core #(
  parameter int  DATA_W  = 18,
  parameter int  WORDS   = 512,
  parameter int  LANES   = 2,
  parameter int  LANE_W  = 9,
  parameter bit  RDW_NEW = 1'b0,
  localparam int AW      = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              clr,
  input  logic              we,
  input  logic              re,
  input  logic              stall,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [AW-1:0]     addr_hold;
  logic [AW-1:0]     addr_use;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] stored;
  logic [DATA_W-1:0] merged;

  assign addr_use = stall ? addr_hold : addr;
  assign lane_en  = (DATA_W < 8) ? {LANES{1'b1}} : be;

  always_comb begin
    stored = mem[addr_use];
    merged = stored;
    for (int l = 0; l < LANES; l++)
      if (lane_en[l])
        merged[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (ce && we)
      for (int l = 0; l < LANES; l++)
        if (lane_en[l])
          mem[addr_use][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr)
      addr_hold <= '0;
    else if (ce)
      addr_hold <= addr_use;
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr)
      rd_q <= '0;
    else if (ce && re)
      rd_q <= (RDW_NEW && we) ? merged : stored;
  end

endmodule

// File: rtl/spram_outreg.sv
module spram_outreg #(
  parameter int DATA_W = 18,
  parameter bit ENABLE = 1'b1
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              clr,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  if (ENABLE) begin : g_reg
    always_ff @(posedge clk or posedge clr) begin
      if (clr)
        q <= '0;
      else if (ce)
        q <= d;
    end
  end else begin : g_pass
    assign q = d;
  end

endmodule

// File: rtl/spram_block.sv
module spram_block #(
  parameter int  DATA_W  = 18,
  parameter int  DEPTH   = 512,
  parameter bit  RDW_NEW = 1'b0,
  parameter bit  OUT_REG = 1'b1,
  parameter bit  PACKED  = 1'b0,
  localparam int NP      = PACKED ? 2 : 1,
  localparam int PDEPTH  = DEPTH / NP,
  localparam int AW      = $clog2(PDEPTH),
  localparam int LW      = spram_pkg::lane_width(DATA_W),
  localparam int NL      = spram_pkg::lane_count(DATA_W)
) (
  input  logic                 clk_in,
  input  logic                 ce_in,
  input  logic                 clk_out,
  input  logic                 ce_out,
  input  logic                 clr,
  input  logic [NP-1:0]        wr_en,
  input  logic [NP-1:0]        rd_en,
  input  logic [NP-1:0]        addr_stall,
  input  logic [NP*AW-1:0]     addr,
  input  logic [NP*DATA_W-1:0] wdata,
  input  logic [NP*NL-1:0]     byte_en,
  output logic [NP*DATA_W-1:0] q
);

  if (!spram_pkg::shape_ok(DATA_W, DEPTH)) begin : g_bad_shape
    $error("spram_block: unsupported shape %0d x %0d", DATA_W, DEPTH);
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [DATA_W-1:0] rd_word;

    spram_core #(
      .DATA_W (DATA_W),
      .WORDS  (PDEPTH),
      .LANES  (NL),
      .LANE_W (LW),
      .RDW_NEW(RDW_NEW)
    ) u_core (
      .clk  (clk_in),
      .ce   (ce_in),
      .clr  (clr),
      .we   (wr_en[p]),
      .re   (rd_en[p]),
      .stall(addr_stall[p]),
      .addr (addr[p*AW +: AW]),
      .wdata(wdata[p*DATA_W +: DATA_W]),
      .be   (byte_en[p*NL +: NL]),
      .rd_q (rd_word)
    );

    spram_outreg #(
      .DATA_W(DATA_W),
      .ENABLE(OUT_REG)
    ) u_out (
      .clk(clk_out),
      .ce (ce_out),
      .clr(clr),
      .d  (rd_word),
      .q  (q[p*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/spram_block_chk.sv
module spram_block_chk #(
  parameter int DATA_W  = 18,
  parameter int NP      = 1,
  parameter int NL      = 2,
  parameter bit RDW_NEW = 1'b0,
  parameter bit OUT_REG = 1'b1
) (
  input logic                 clk_in,
  input logic                 ce_in,
  input logic                 clk_out,
  input logic                 ce_out,
  input logic                 clr,
  input logic [NP-1:0]        wr_en,
  input logic [NP-1:0]        rd_en,
  input logic [NP*NL-1:0]     byte_en,
  input logic [NP*DATA_W-1:0] wdata,
  input logic [NP*DATA_W-1:0] q
);

  // R11: output is zero whenever clear is applied
  a_r11_clear_zero: assert property (@(posedge clk_in) clr |-> (q == '0));

  if (OUT_REG) begin : g_reg_chk
    // R10: output register holds while its enable is low
    a_r10_hold_ce_out: assert property (@(posedge clk_out) disable iff (clr)
      !ce_out |=> $stable(q));
  end else begin : g_direct_chk
    // R5, R9: no enabled read means the port-0 output holds
    a_r5_hold_no_read: assert property (@(posedge clk_in) disable iff (clr)
      !(ce_in && rd_en[0]) |=> $stable(q[DATA_W-1:0]));
    if (RDW_NEW) begin : g_new_chk
      // R3: full-word write with read returns the written word
      a_r3_new_data: assert property (@(posedge clk_in) disable iff (clr)
        (ce_in && wr_en[0] && rd_en[0] && (&byte_en[NL-1:0]))
        |=> (q[DATA_W-1:0] == $past(wdata[DATA_W-1:0])));
    end
  end

endmodule

bind spram_block spram_block_chk #(
  .DATA_W (DATA_W),
  .NP     (NP),
  .NL     (NL),
  .RDW_NEW(RDW_NEW),
  .OUT_REG(OUT_REG)
) u_chk (
  .clk_in (clk_in),
  .ce_in  (ce_in),
  .clk_out(clk_out),
  .ce_out (ce_out),
  .clr    (clr),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .byte_en(byte_en),
  .wdata  (wdata),
  .q      (q)
);

// File: tb/spram_block_tb.sv
module spram_block_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic clr = 1'b1;

  // Instance A: 18 x 512, old-data read-during-write, no output register
  logic        a_ce = 1'b1, a_we = 1'b0, a_re = 1'b0, a_st = 1'b0;
  logic [8:0]  a_addr = '0;
  logic [17:0] a_wd = '0;
  logic [1:0]  a_be = 2'b11;
  logic [17:0] a_q;

  spram_block #(.DATA_W(18), .DEPTH(512), .RDW_NEW(1'b0), .OUT_REG(1'b0), .PACKED(1'b0)) u_dut (
    .clk_in(clk), .ce_in(a_ce), .clk_out(clk), .ce_out(1'b1), .clr(clr),
    .wr_en(a_we), .rd_en(a_re), .addr_stall(a_st), .addr(a_addr),
    .wdata(a_wd), .byte_en(a_be), .q(a_q));

  // Instance B: 8 x 1024 packed, new-data read-during-write, output register
  logic        b_ceo = 1'b1;
  logic [1:0]  b_we = '0, b_re = '0;
  logic [17:0] b_addr = '0;
  logic [15:0] b_wd = '0;
  logic [15:0] b_q;

  spram_block #(.DATA_W(8), .DEPTH(1024), .RDW_NEW(1'b1), .OUT_REG(1'b1), .PACKED(1'b1)) u_dut_pk (
    .clk_in(clk), .ce_in(1'b1), .clk_out(clk), .ce_out(b_ceo), .clr(clr),
    .wr_en(b_we), .rd_en(b_re), .addr_stall(2'b00), .addr(b_addr),
    .wdata(b_wd), .byte_en(2'b11), .q(b_q));

  // Instance C: 4 x 2048, narrow word
  logic        c_we = 1'b0, c_re = 1'b0;
  logic [10:0] c_addr = '0;
  logic [3:0]  c_wd = '0;
  logic [3:0]  c_q;

  spram_block #(.DATA_W(4), .DEPTH(2048), .RDW_NEW(1'b0), .OUT_REG(1'b0), .PACKED(1'b0)) u_dut_nw (
    .clk_in(clk), .ce_in(1'b1), .clk_out(clk), .ce_out(1'b1), .clr(clr),
    .wr_en(c_we), .rd_en(c_re), .addr_stall(1'b0), .addr(c_addr),
    .wdata(c_wd), .byte_en(1'b0), .q(c_q));

  typedef struct packed {
    logic        we;
    logic        re;
    logic [1:0]  be;
    logic [8:0]  addr;
    logic [17:0] data;
    logic [17:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'b11, 9'd5, 18'h12345, 18'h00000},
    '{1'b1, 1'b0, 2'b11, 9'd6, 18'h00ABC, 18'h00000},
    '{1'b0, 1'b1, 2'b11, 9'd5, 18'h00000, 18'h12345},
    '{1'b1, 1'b1, 2'b11, 9'd6, 18'h3FFFF, 18'h00ABC},
    '{1'b0, 1'b1, 2'b11, 9'd6, 18'h00000, 18'h3FFFF},
    '{1'b1, 1'b0, 2'b01, 9'd5, 18'h001FF, 18'h3FFFF},
    '{1'b0, 1'b1, 2'b11, 9'd5, 18'h00000, 18'h123FF},
    '{1'b1, 1'b1, 2'b10, 9'd5, 18'h3FE00, 18'h123FF},
    '{1'b0, 1'b1, 2'b11, 9'd5, 18'h00000, 18'h3FFFF},
    '{1'b1, 1'b1, 2'b00, 9'd6, 18'h00000, 18'h3FFFF},
    '{1'b0, 1'b1, 2'b11, 9'd6, 18'h00000, 18'h3FFFF}
  };
  localparam string TAGS [NV] = '{"R2/R5", "R2/R5", "R2", "R4", "R2", "R5",
                                  "R6", "R4/R6", "R6", "R4/R6", "R6"};

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_op(logic we, logic re, logic st, logic [8:0] ad, logic [17:0] wd);
    a_we = we; a_re = re; a_st = st; a_addr = ad; a_wd = wd; a_be = 2'b11;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    check("R11 reset A", {14'd0, a_q}, 32'h0);
    check("R11 reset B", {16'd0, b_q}, 32'h0);
    check("R11 reset C", {28'd0, c_q}, 32'h0);
    clr = 1'b0;
    tick();

    for (int i = 0; i < NV; i++) begin
      a_we = VECS[i].we; a_re = VECS[i].re; a_be = VECS[i].be;
      a_addr = VECS[i].addr; a_wd = VECS[i].data;
      tick();
      check(TAGS[i], {14'd0, a_q}, {14'd0, VECS[i].exp});
    end

    // R1: top address is a distinct word
    a_op(1'b1, 1'b0, 1'b0, 9'd511, 18'h2AAAA);
    a_op(1'b0, 1'b1, 1'b0, 9'd511, 18'h0);
    check("R1 top address", {14'd0, a_q}, 32'h2AAAA);
    a_op(1'b0, 1'b1, 1'b0, 9'd5, 18'h0);
    check("R1 low address kept", {14'd0, a_q}, 32'h3FFFF);

    // R9: clock enable low blocks write, read and address latch
    a_ce = 1'b0;
    a_op(1'b1, 1'b1, 1'b0, 9'd511, 18'h0);
    check("R9 output holds", {14'd0, a_q}, 32'h3FFFF);
    a_ce = 1'b1;
    a_op(1'b0, 1'b1, 1'b0, 9'd511, 18'h0);
    check("R9 no write", {14'd0, a_q}, 32'h2AAAA);

    // R8: address stall
    a_op(1'b1, 1'b0, 1'b0, 9'd7, 18'h0C0DE);
    a_op(1'b0, 1'b1, 1'b1, 9'd9, 18'h0);
    check("R8 stalled read", {14'd0, a_q}, 32'h0C0DE);
    a_op(1'b1, 1'b0, 1'b1, 9'd9, 18'h11111);
    a_op(1'b0, 1'b1, 1'b0, 9'd7, 18'h0);
    check("R8 stalled write", {14'd0, a_q}, 32'h11111);

    // R11: clear zeroes output and latched address, keeps memory
    a_op(1'b1, 1'b0, 1'b0, 9'd0, 18'h00077);
    a_we = 1'b0; a_re = 1'b0;
    #3 clr = 1'b1;
    #1 check("R11 async clear", {14'd0, a_q}, 32'h0);
    tick();
    clr = 1'b0;
    a_op(1'b0, 1'b1, 1'b1, 9'd9, 18'h0);
    check("R11 address cleared, memory kept", {14'd0, a_q}, 32'h00077);
    a_re = 1'b0;

    // B: packed, new data, output register
    b_we = 2'b01; b_re = 2'b01; b_addr = {9'd0, 9'd3}; b_wd = 16'h00A5;
    tick();
    check("R10 latency", {16'd0, b_q}, 32'h0);
    b_we = 2'b00; b_re = 2'b00;
    tick();
    check("R3/R10 new data", {24'd0, b_q[7:0]}, 32'hA5);
    b_we = 2'b10; b_re = 2'b11; b_addr = {9'd3, 9'd3}; b_wd = 16'h5A00;
    tick();
    b_we = 2'b00; b_re = 2'b00;
    tick();
    check("R12 port1", {24'd0, b_q[15:8]}, 32'h5A);
    check("R12 port0 separate", {24'd0, b_q[7:0]}, 32'hA5);
    b_ceo = 1'b0;
    b_we = 2'b01; b_re = 2'b01; b_addr = {9'd0, 9'd4}; b_wd = 16'h003C;
    tick();
    b_we = 2'b00; b_re = 2'b00;
    tick();
    check("R10 ce_out hold", {24'd0, b_q[7:0]}, 32'hA5);
    b_ceo = 1'b1;
    tick();
    check("R10 ce_out release", {24'd0, b_q[7:0]}, 32'h3C);

    // C: narrow word ignores byte enable
    c_we = 1'b1; c_addr = 11'd10; c_wd = 4'h9;
    tick();
    c_we = 1'b0; c_re = 1'b1;
    tick();
    check("R7 narrow write", {28'd0, c_q}, 32'h9);
    c_we = 1'b1; c_re = 1'b0; c_addr = 11'd2047; c_wd = 4'h6;
    tick();
    c_we = 1'b0; c_re = 1'b1;
    tick();
    check("R1 narrow top address", {28'd0, c_q}, 32'h6);
    c_re = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule